// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the integer arithmetic slice of a small soft processor core. It combines two operands under a 3-bit opcode. The operations are addition, reverse subtraction (second operand minus first), signed and unsigned magnitude compare, and a byte-lane search that reports the first equal byte. The result path is purely combinational. A one-bit carry flag and a shadow copy of it are held in registers beside the datapath.

Add and reverse subtract can take their carry-in from the stored carry flag. A keep control lets an instruction use the carry without changing it. The compare operations do not produce flags. Instead they patch the most significant bit of the difference, so that branch logic further on can test the sign of the result. Flag writes happen on the rising clock edge of a cycle in which the issue strobe is high.

Top module: `arith_unit`

## Requirements
- R1: Opcode 0 (add) drives result = a + b + cin (modulo 2^32). cin is the stored carry flag when use_carry is 1, and 0 when use_carry is 0.
- R2: Opcode 1 (reverse subtract) drives result = b + ~a + cin, which is b minus a. cin is the stored carry flag when use_carry is 1, and 1 when use_carry is 0.
- R3: For opcodes 0 and 1 with issue high and keep low, the carry out of the 33-bit sum is stored into both carry_flag and carry_shadow at the next rising clock edge.
- R4: When keep is 1, neither carry_flag nor carry_shadow changes, whatever the opcode.
- R5: Opcode 2 (signed compare) drives b minus a. When bit 31 of a differs from bit 31 of b, bit 31 of the result is replaced by bit 31 of b.
- R6: Opcode 3 (unsigned compare) drives b minus a. When bit 31 of a differs from bit 31 of b, bit 31 of the result is replaced by bit 31 of a.
- R7: Opcode 4 (byte-lane search) compares the byte lanes in order bits 31:24, 23:16, 15:8, 7:0. It drives 1, 2, 3 or 4 for the first lane in that order where a and b are equal, and 0 when no lane is equal.
- R8: Opcodes 2 through 7 never change the carry flags. Opcodes 5 to 7 drive a result of 0. With issue low, no opcode changes the flags.
- R9: A synchronous active-high reset clears carry_flag and carry_shadow to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation valid; allows the flag write |
| op | input | 3 | Opcode: 0 add, 1 reverse subtract, 2 signed compare, 3 unsigned compare, 4 byte-lane search |
| use_carry | input | 1 | Take carry-in from the stored carry flag |
| keep | input | 1 | Do not update the carry flags |
| opa | input | 32 | First operand (a) |
| opb | input | 32 | Second operand (b) |
| result | output | 32 | Combinational result |
| carry_flag | output | 1 | Stored carry flag |
| carry_shadow | output | 1 | Shadow copy of the carry flag |

## Verification
The assertions check on every cycle that flags stay put under keep, under compare and search opcodes, and with issue low. They also check that a flag write stores the carry just produced, that reset clears both flags, that subtracting equal operands with the default carry-in yields zero with carry set, and that the lane index never exceeds the lane count. The exact sums and carries of add and subtract with each carry-in source, the MSB patching of the two compares for mixed-sign operands, and the priority order of the lane search can only be shown by the bench's directed scenarios against its own model.

// File: rtl/arith_pkg.sv
package arith_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        AOP_ADD   = 3'd0,
        AOP_RSUB  = 3'd1,
        AOP_CMPS  = 3'd2,
        AOP_CMPU  = 3'd3,
        AOP_LANEQ = 3'd4
    } arith_op_e;

    typedef struct packed {
        logic carry;
        logic shadow;
    } flag_pair_t;

    function automatic logic op_writes_carry(input arith_op_e o);
        return (o == AOP_ADD) || (o == AOP_RSUB);
    endfunction

endpackage

// File: rtl/arith_addsub.sv
module arith_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic [W:0]   wide;

    always_comb begin
        lhs  = sub ? b : a;
        rhs  = sub ? ~a : b;
        wide = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end

    // R2: b - b with carry-in one gives zero and a carry out
    always_comb begin
        a_r2_equal_sub_zero: assert (!(sub && cin && (a == b)) || ((sum == '0) && cout));
    end

endmodule

// File: rtl/arith_cmp.sv
module arith_cmp #(
    parameter int W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    logic [W-1:0] diff;
    logic         mixed;

    always_comb begin
        diff  = b - a;
        mixed = a[W-1] ^ b[W-1];
        res   = diff;
        if (mixed) begin
            res[W-1] = signed_mode ? b[W-1] : a[W-1];
        end
    end

endmodule

// File: rtl/arith_lanematch.sv
module arith_lanematch #(
    parameter int W  = 32,
    parameter int LW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] idx
);
    localparam int LANES = W / LW;

    logic [LANES-1:0] eq;

    // eq[0] is the most significant lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = W - 1 - g * LW;
        assign eq[g] = (a[HI -: LW] == b[HI -: LW]);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && eq[i]) begin
                idx   = W'(i + 1);
                found = 1'b1;
            end
        end
    end

    // R7: index never exceeds the lane count
    always_comb begin
        a_r7_idx_range: assert (idx <= W'(LANES));
    end

endmodule

// File: rtl/arith_flags.sv
module arith_flags
    import arith_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       cout,
    output flag_pair_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (wr) begin
            flags.carry  <= cout;
            flags.shadow <= cout;
        end
    end

    // R9: synchronous reset clears both flags
    a_r9_reset_clear: assert property (@(posedge clk) rst |=> (flags == '0));

    // R3: a write stores the carry presented to it
    a_r3_write_value: assert property (@(posedge clk) disable iff (rst)
        wr |=> (flags.carry == $past(cout)) && (flags.shadow == $past(cout)));

endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import arith_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int LW = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         issue,
    input  logic [2:0]   op,
    input  logic         use_carry,
    input  logic         keep,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         carry_flag,
    output logic         carry_shadow
);
    arith_op_e    opc;
    flag_pair_t   flags;
    logic         is_sub;
    logic         cin;
    logic         cout;
    logic         flag_wr;
    logic [W-1:0] sum;
    logic [W-1:0] cmp_res;
    logic [W-1:0] lane_idx;

    always_comb begin
        opc     = arith_op_e'(op);
        is_sub  = (opc == AOP_RSUB);
        cin     = use_carry ? flags.carry : is_sub;
        flag_wr = issue && !keep && op_writes_carry(opc);
    end

    arith_addsub #(.W(W)) u_addsub (
        .sub  (is_sub),
        .cin  (cin),
        .a    (opa),
        .b    (opb),
        .sum  (sum),
        .cout (cout)
    );

    arith_cmp #(.W(W)) u_cmp (
        .signed_mode (opc == AOP_CMPS),
        .a           (opa),
        .b           (opb),
        .res         (cmp_res)
    );

    arith_lanematch #(.W(W), .LW(LW)) u_lane (
        .a   (opa),
        .b   (opb),
        .idx (lane_idx)
    );

    arith_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .wr    (flag_wr),
        .cout  (cout),
        .flags (flags)
    );

    always_comb begin
        unique case (opc)
            AOP_ADD, AOP_RSUB: result = sum;
            AOP_CMPS, AOP_CMPU: result = cmp_res;
            AOP_LANEQ: result = lane_idx;
            default: result = '0;
        endcase
    end

    assign carry_flag   = flags.carry;
    assign carry_shadow = flags.shadow;

    // R4: keep freezes both flags
    a_r4_keep_hold: assert property (@(posedge clk) disable iff (rst)
        (issue && keep) |=> ($stable(carry_flag) && $stable(carry_shadow)));

    // R8: compare, search and unused opcodes leave flags alone
    a_r8_nonarith_hold: assert property (@(posedge clk) disable iff (rst)
        (op >= 3'd2) |=> ($stable(carry_flag) && $stable(carry_shadow)));

    // R8: no write without issue
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(carry_flag));

    // R1: adding zero without carry-in passes the first operand through
    always_comb begin
        a_r1_add_zero: assert (!(op == 3'd0 && !use_carry && opb == '0) || (result == opa));
    end

endmodule

// File: tb/tb_arith_unit.sv
module tb_arith_unit;

    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         issue;
    logic [2:0]   op;
    logic         use_carry;
    logic         keep;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] result;
    logic         carry_flag;
    logic         carry_shadow;

    int checks   = 0;
    int failures = 0;
    logic model_c = 1'b0;
    bit   done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arith_unit dut (
        .clk          (clk),
        .rst          (rst),
        .issue        (issue),
        .op           (op),
        .use_carry    (use_carry),
        .keep         (keep),
        .opa          (opa),
        .opb          (opb),
        .result       (result),
        .carry_flag   (carry_flag),
        .carry_shadow (carry_shadow)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference built from the requirement text
    task automatic model(input logic [2:0] o, input logic uc, input logic [W-1:0] a,
                         input logic [W-1:0] b, output logic [W-1:0] res, output logic co,
                         output logic wr);
        logic [W:0] s;
        logic       ci;
        res = '0; co = 1'b0; wr = 1'b0;
        case (o)
            3'd0: begin
                ci = uc ? model_c : 1'b0;
                s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
                res = s[W-1:0]; co = s[W]; wr = 1'b1;
            end
            3'd1: begin
                ci = uc ? model_c : 1'b1;
                s = {1'b0, b} + {1'b0, ~a} + {{W{1'b0}}, ci};
                res = s[W-1:0]; co = s[W]; wr = 1'b1;
            end
            3'd2, 3'd3: begin
                res = b - a;
                if (a[W-1] != b[W-1]) res[W-1] = (o == 3'd2) ? b[W-1] : a[W-1];
            end
            3'd4: begin
                for (int i = 3; i >= 0; i--)
                    if (a[8*i +: 8] == b[8*i +: 8] && res == '0) res = W'(4 - i);
            end
            default: res = '0;
        endcase
    endtask

    task automatic run_op(input string tag, input logic [2:0] o, input logic uc,
                          input logic k, input logic iss, input logic [W-1:0] a,
                          input logic [W-1:0] b);
        logic [W-1:0] er;
        logic eco, ewr;
        @(negedge clk);
        issue = iss; op = o; use_carry = uc; keep = k; opa = a; opb = b;
        model(o, uc, a, b, er, eco, ewr);
        #1 check({tag, " result"}, result, er);
        @(posedge clk);
        if (iss && !k && ewr) model_c = eco;
        #1;
        check({tag, " carry_flag"}, {31'd0, carry_flag}, {31'd0, model_c});
        check({tag, " carry_shadow"}, {31'd0, carry_shadow}, {31'd0, model_c});
        issue = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; issue = 0; op = 0; use_carry = 0; keep = 0; opa = 0; opb = 0;
        repeat (2) @(posedge clk);
        #1 check("R9 reset flag", {31'd0, carry_flag}, 32'd0);
        check("R9 reset shadow", {31'd0, carry_shadow}, 32'd0);
        @(negedge clk) rst = 1'b0;
        model_c = 1'b0;
    endtask

    task automatic t_add;
        run_op("R1 add plain", 3'd0, 0, 0, 1, 32'h0000_1234, 32'h0000_0F0F);
        run_op("R3 add carry out", 3'd0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
        run_op("R1 add with carry in", 3'd0, 1, 0, 1, 32'h0000_0010, 32'h0000_0020);
        run_op("R3 add ones plus cin", 3'd0, 1, 0, 1, 32'h0000_0000, 32'hFFFF_FFFF);
        run_op("R3 add clears carry", 3'd0, 0, 0, 1, 32'h0000_0001, 32'h0000_0001);
    endtask

    task automatic t_sub;
        run_op("R2 sub equal", 3'd1, 0, 0, 1, 32'h0000_0055, 32'h0000_0055);
        run_op("R2 sub borrow", 3'd1, 0, 0, 1, 32'h0000_0009, 32'h0000_0004);
        run_op("R2 sub with stored cin 0", 3'd1, 1, 0, 1, 32'h0000_0002, 32'h0000_0010);
        run_op("R2 sub with stored cin 1", 3'd1, 1, 0, 1, 32'h0000_0002, 32'h0000_0010);
    endtask

    task automatic t_keep;
        run_op("R3 set carry", 3'd0, 0, 0, 1, 32'h8000_0000, 32'h8000_0000);
        run_op("R4 keep add", 3'd0, 0, 1, 1, 32'h0000_0001, 32'h0000_0001);
        run_op("R4 keep sub", 3'd1, 1, 1, 1, 32'h0000_0003, 32'h0000_0001);
        run_op("R8 idle add", 3'd0, 0, 0, 0, 32'h0000_0001, 32'h0000_0002);
    endtask

    task automatic t_cmp;
        run_op("R5 cmp same sign", 3'd2, 0, 0, 1, 32'd5, 32'd3);
        run_op("R5 cmp mixed sign", 3'd2, 0, 0, 1, 32'h8000_0000, 32'h0000_0001);
        run_op("R6 cmpu mixed sign", 3'd3, 0, 0, 1, 32'h8000_0000, 32'h0000_0001);
        run_op("R6 cmpu neg b", 3'd3, 1, 0, 1, 32'h0000_0001, 32'hF000_0000);
        // explicit values for the patched MSB
        @(negedge clk); op = 3'd2; opa = 32'h8000_0000; opb = 32'h0000_0001;
        #1 check("R5 cmp explicit", result, 32'h0000_0001);
        op = 3'd3;
        #1 check("R6 cmpu explicit", result, 32'h8000_0001);
    endtask

    task automatic t_lane;
        run_op("R7 lane top", 3'd4, 0, 0, 1, 32'h1122_3344, 32'h1100_0000);
        run_op("R7 lane two", 3'd4, 0, 0, 1, 32'h1122_3344, 32'h0022_3300);
        run_op("R7 lane three", 3'd4, 0, 0, 1, 32'h1122_3344, 32'h0000_3344);
        run_op("R7 lane four", 3'd4, 0, 0, 1, 32'h1122_3344, 32'h0000_0044);
        run_op("R7 lane none", 3'd4, 0, 0, 1, 32'h1122_3344, 32'h2233_4455);
        @(negedge clk); op = 3'd4; opa = 32'hAB00_00CD; opb = 32'h0000_00CD;
        #1 check("R7 lane explicit", result, 32'd2);
    endtask

    task automatic t_other;
        run_op("R3 set carry again", 3'd0, 0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R8 cmp holds flag", 3'd2, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0000);
        run_op("R8 op5", 3'd5, 1, 0, 1, 32'h1234_5678, 32'h1234_5678);
        run_op("R8 op7", 3'd7, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_keep();
        t_cmp();
        t_lane();
        t_other();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule